// File: doc/BRIEF.md
# Load/Store Address Alignment and Lane Formatting Unit

This block sits between an integer pipeline and a 32-bit data bus and handles byte, halfword and word memory accesses. For each request it forms the effective address by adding a sign-extended 16-bit displacement to a base value. It then checks that the address is naturally aligned for the access size. For stores it steers the data onto the byte lanes and raises only the enables of the addressed lanes. An access that is not aligned produces a fault flag for the load or store side, together with the address that caused it, and never reaches the bus.

Loads are handled in two steps. The request phase captures the lane offset, size and extension mode of the load. When the bus later returns a word, marked by a response strobe, the unit picks the addressed byte or halfword out of that word and widens it to 32 bits. Bytes are numbered little-endian: address bits 1:0 select lane 0 (bits 7:0) to lane 3 (bits 31:24). Every output is registered. Bus-side outputs appear on the clock edge after the request, and the load result appears on the clock edge after the response strobe.

Opcode values: signed byte load 32, signed halfword load 33, word load 35, unsigned byte load 36, unsigned halfword load 37, byte store 40, halfword store 41, word store 43. No other value starts an access.

Top module: `lsu_align_unit`

## Requirements
- R1: One cycle after a request, `mem_addr` equals `req_base` plus `req_disp` sign-extended to 32 bits, computed modulo 2^32.
- R2: An aligned byte store sets `mem_we`, sets `mem_be` to a single bit at position address[1:0], and drives the low byte of `req_st_data` onto all four lanes of `mem_wdata`.
- R3: An aligned halfword store sets `mem_be` to 4'b0011 when address bit 1 is 0 and to 4'b1100 when it is 1, and drives the low halfword of `req_st_data` onto both halves of `mem_wdata`.
- R4: An aligned word store sets `mem_be` to 4'b1111 and drives `req_st_data` unchanged.
- R5: A halfword access with address bit 0 set, or a word access with address bits 1:0 not zero, raises `err_load` or `err_store` (matching its direction) for one cycle. It leaves `mem_be` at zero and `mem_we`/`mem_re` low, and loads its effective address into `fault_addr`. `fault_addr` holds that value until the next fault. Byte accesses never fault.
- R6: An aligned load sets `mem_re` and the lane enables for its size (as in R2 to R4). One cycle after `rsp_valid`, `ld_valid` is high and `ld_data` holds the byte at lane address[1:0] of `rsp_rdata`. This byte is sign-extended for opcode 32 and zero-extended for opcode 36.
- R7: A halfword load returns the halfword at `rsp_rdata` bits 15:0 (address bit 1 = 0) or bits 31:16 (address bit 1 = 1). It is sign-extended for opcode 33 and zero-extended for opcode 37.
- R8: A word load returns `rsp_rdata` unchanged.
- R9: An opcode outside the eight listed values, or `req_valid` low, drives no enables, no strobes and no fault.
- R10: While `rst` is high, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request strobe |
| req_op | input | 6 | Access opcode |
| req_base | input | 32 | Base register value |
| req_disp | input | 16 | Signed displacement |
| req_st_data | input | 32 | Store data, right-aligned |
| rsp_valid | input | 1 | Read word returned by the bus |
| rsp_rdata | input | 32 | Returned read word |
| mem_addr | output | 32 | Effective address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |
| err_load | output | 1 | Misaligned load fault |
| err_store | output | 1 | Misaligned store fault |
| fault_addr | output | 32 | Address of the last fault |

## Verification
The bench drives byte stores through every lane and halfword stores through both halves. A design with a wrong lane index would enable the wrong lane, and one that does not replicate the data would leave stale data on the lane that is enabled. Loads use a returned word whose bytes alternate in sign bit, so signed and unsigned extension give different results; mixing up opcodes 32/36 or 33/37, or picking the wrong half, produces a visibly wrong value. The misalignment tests use halfword offset 1 and word offsets 2 and 3, plus a byte access at offset 3 that must pass. A design that checks the wrong address bits would either fault on a legal access or let a strobe through. The tests also confirm that the fault address survives later clean accesses. A negative displacement exposes zero-extension of the offset, and an opcode outside the set must stay silent.

// File: rtl/lsu_align_pkg.sv
`timescale 1ns/1ps
package lsu_align_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_NONE = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic      is_load;
    logic      is_store;
    logic      zero_ext;
    acc_size_e size;
  } acc_decode_t;

  localparam logic [5:0] OP_LD_B  = 6'd32;
  localparam logic [5:0] OP_LD_H  = 6'd33;
  localparam logic [5:0] OP_LD_W  = 6'd35;
  localparam logic [5:0] OP_LD_BU = 6'd36;
  localparam logic [5:0] OP_LD_HU = 6'd37;
  localparam logic [5:0] OP_ST_B  = 6'd40;
  localparam logic [5:0] OP_ST_H  = 6'd41;
  localparam logic [5:0] OP_ST_W  = 6'd43;

  function automatic acc_decode_t decode_op(input logic [5:0] op);
    acc_decode_t d;
    d = '{is_load: 1'b0, is_store: 1'b0, zero_ext: 1'b0, size: SZ_NONE};
    case (op)
      OP_LD_B:  d = '{is_load: 1'b1, is_store: 1'b0, zero_ext: 1'b0, size: SZ_BYTE};
      OP_LD_H:  d = '{is_load: 1'b1, is_store: 1'b0, zero_ext: 1'b0, size: SZ_HALF};
      OP_LD_W:  d = '{is_load: 1'b1, is_store: 1'b0, zero_ext: 1'b0, size: SZ_WORD};
      OP_LD_BU: d = '{is_load: 1'b1, is_store: 1'b0, zero_ext: 1'b1, size: SZ_BYTE};
      OP_LD_HU: d = '{is_load: 1'b1, is_store: 1'b0, zero_ext: 1'b1, size: SZ_HALF};
      OP_ST_B:  d = '{is_load: 1'b0, is_store: 1'b1, zero_ext: 1'b0, size: SZ_BYTE};
      OP_ST_H:  d = '{is_load: 1'b0, is_store: 1'b1, zero_ext: 1'b0, size: SZ_HALF};
      OP_ST_W:  d = '{is_load: 1'b0, is_store: 1'b1, zero_ext: 1'b0, size: SZ_WORD};
      default:  d = '{is_load: 1'b0, is_store: 1'b0, zero_ext: 1'b0, size: SZ_NONE};
    endcase
    return d;
  endfunction

endpackage

// File: rtl/lsu_agu.sv
`timescale 1ns/1ps
module lsu_agu
  import lsu_align_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int OFF_W  = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [DISP_W-1:0] disp,
  input  acc_size_e         size,
  output logic [ADDR_W-1:0] ea,
  output logic              misaligned
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_sx;

  always_comb begin
    disp_sx = {{EXT_W{disp[DISP_W-1]}}, disp};
    ea      = base + disp_sx;
    case (size)
      SZ_HALF: misaligned = ea[0];
      SZ_WORD: misaligned = |ea[OFF_W-1:0];
      default: misaligned = 1'b0;
    endcase
  end
endmodule

// File: rtl/lsu_store_lanes.sv
`timescale 1ns/1ps
module lsu_store_lanes
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int OFF_W  = $clog2(LANES)
) (
  input  acc_size_e         size,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] st_data,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] wdata
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [OFF_W-1:0] LANE_IDX = OFF_W'(i);
    always_comb begin
      case (size)
        SZ_BYTE: begin
          be[i]          = (off == LANE_IDX);
          wdata[8*i +: 8] = st_data[7:0];
        end
        SZ_HALF: begin
          be[i]          = (off[OFF_W-1:1] == LANE_IDX[OFF_W-1:1]);
          wdata[8*i +: 8] = st_data[8*(i%2) +: 8];
        end
        SZ_WORD: begin
          be[i]          = 1'b1;
          wdata[8*i +: 8] = st_data[8*i +: 8];
        end
        default: begin
          be[i]          = 1'b0;
          wdata[8*i +: 8] = 8'h00;
        end
      endcase
    end
  end
endmodule

// File: rtl/lsu_load_extract.sv
`timescale 1ns/1ps
module lsu_load_extract
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int OFF_W  = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] rdata,
  input  logic [OFF_W-1:0]  off,
  input  acc_size_e         size,
  input  logic              zero_ext,
  output logic [DATA_W-1:0] result
);
  logic [7:0]  sel_b;
  logic [15:0] sel_h;
  logic        fill_b;
  logic        fill_h;

  always_comb begin
    sel_b  = rdata[8*off +: 8];
    sel_h  = rdata[16*off[OFF_W-1:1] +: 16];
    fill_b = ~zero_ext & sel_b[7];
    fill_h = ~zero_ext & sel_h[15];
    case (size)
      SZ_BYTE: result = {{(DATA_W-8){fill_b}}, sel_b};
      SZ_HALF: result = {{(DATA_W-16){fill_h}}, sel_h};
      default: result = rdata;
    endcase
  end
endmodule

// File: rtl/lsu_align_unit.sv
`timescale 1ns/1ps
module lsu_align_unit
  import lsu_align_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int DATA_W = 32,
  parameter int OP_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [OP_W-1:0]   req_op,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [DISP_W-1:0] req_disp,
  input  logic [DATA_W-1:0] req_st_data,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W/8-1:0] mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data,
  output logic              err_load,
  output logic              err_store,
  output logic [ADDR_W-1:0] fault_addr
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  typedef struct packed {
    logic [OFF_W-1:0] off;
    acc_size_e        size;
    logic             zero_ext;
  } ld_ctx_t;

  acc_decode_t       dec;
  logic [ADDR_W-1:0] ea;
  logic              misaligned;
  logic [LANES-1:0]  lane_be;
  logic [DATA_W-1:0] lane_wdata;
  logic [DATA_W-1:0] ld_fmt;
  logic              go;
  logic              fault;
  logic              clean;
  ld_ctx_t           ctx_q;

  always_comb begin
    dec   = decode_op(req_op);
    go    = req_valid & (dec.is_load | dec.is_store);
    fault = go & misaligned;
    clean = go & ~misaligned;
  end

  lsu_agu #(
    .ADDR_W(ADDR_W), .DISP_W(DISP_W), .OFF_W(OFF_W)
  ) u_agu (
    .base(req_base), .disp(req_disp), .size(dec.size),
    .ea(ea), .misaligned(misaligned)
  );

  lsu_store_lanes #(
    .DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W)
  ) u_lanes (
    .size(dec.size), .off(ea[OFF_W-1:0]), .st_data(req_st_data),
    .be(lane_be), .wdata(lane_wdata)
  );

  lsu_load_extract #(
    .DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W)
  ) u_extract (
    .rdata(rsp_rdata), .off(ctx_q.off), .size(ctx_q.size),
    .zero_ext(ctx_q.zero_ext), .result(ld_fmt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr   <= '0;
      mem_be     <= '0;
      mem_wdata  <= '0;
      mem_we     <= 1'b0;
      mem_re     <= 1'b0;
      err_load   <= 1'b0;
      err_store  <= 1'b0;
      fault_addr <= '0;
      ctx_q      <= '{off: '0, size: SZ_BYTE, zero_ext: 1'b0};
      ld_valid   <= 1'b0;
      ld_data    <= '0;
    end else begin
      if (req_valid) mem_addr <= ea;
      mem_be    <= clean ? lane_be : '0;
      mem_wdata <= (clean & dec.is_store) ? lane_wdata : '0;
      mem_we    <= clean & dec.is_store;
      mem_re    <= clean & dec.is_load;
      err_load  <= fault & dec.is_load;
      err_store <= fault & dec.is_store;
      if (fault) fault_addr <= ea;
      if (clean & dec.is_load)
        ctx_q <= '{off: ea[OFF_W-1:0], size: dec.size, zero_ext: dec.zero_ext};
      ld_valid <= rsp_valid;
      if (rsp_valid) ld_data <= ld_fmt;
    end
  end
endmodule

// File: rtl/lsu_align_chk.sv
`timescale 1ns/1ps
module lsu_align_chk #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int DATA_W = 32,
  parameter int OP_W   = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_base,
  input logic [DISP_W-1:0] req_disp,
  input logic [DATA_W-1:0] req_st_data,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W/8-1:0] mem_be,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_we,
  input logic              mem_re,
  input logic              ld_valid,
  input logic              err_load,
  input logic              err_store,
  input logic [ADDR_W-1:0] fault_addr
);
  localparam int EXT_W = ADDR_W - DISP_W;
  localparam int LANES = DATA_W / 8;

  assert_ea_sum_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(req_valid) && !$past(rst)) |->
      mem_addr == $past(req_base) + {{EXT_W{$past(req_disp[DISP_W-1])}}, $past(req_disp)});

  assert_store_one_group_R2: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ($countones(mem_be) == 1 || mem_be == 4'b0011 ||
                mem_be == 4'b1100 || mem_be == 4'b1111));

  assert_word_passthru_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mem_be == {LANES{1'b1}}) |-> mem_wdata == $past(req_st_data));

  assert_fault_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (err_load || err_store) |-> (mem_be == '0 && !mem_we && !mem_re));

  assert_fault_addr_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !(err_load || err_store) |-> $stable(fault_addr));

  assert_ld_follows_rsp_R6: assert property (@(posedge clk) disable iff (rst)
    ld_valid |-> $past(rsp_valid));

  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_we, mem_re, err_load, err_store}));

  assert_idle_no_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(req_valid) |-> (!mem_we && !mem_re && mem_be == '0));
endmodule

bind lsu_align_unit lsu_align_chk #(
  .ADDR_W(ADDR_W), .DISP_W(DISP_W), .DATA_W(DATA_W), .OP_W(OP_W)
) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_base(req_base),
  .req_disp(req_disp), .req_st_data(req_st_data), .rsp_valid(rsp_valid),
  .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
  .mem_we(mem_we), .mem_re(mem_re), .ld_valid(ld_valid),
  .err_load(err_load), .err_store(err_store), .fault_addr(fault_addr)
);

// File: tb/lsu_align_unit_tb.sv
`timescale 1ns/1ps
module lsu_align_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [5:0]  req_op = '0;
  logic [31:0] req_base = '0;
  logic [15:0] req_disp = '0;
  logic [31:0] req_st_data = '0;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_rdata = '0;
  logic [31:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic        mem_we;
  logic        mem_re;
  logic        ld_valid;
  logic [31:0] ld_data;
  logic        err_load;
  logic        err_store;
  logic [31:0] fault_addr;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  lsu_align_unit dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_base(req_base), .req_disp(req_disp), .req_st_data(req_st_data),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .ld_valid(ld_valid), .ld_data(ld_data), .err_load(err_load),
    .err_store(err_store), .fault_addr(fault_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [5:0] op, input logic [31:0] base,
                       input logic [15:0] disp, input logic [31:0] sd, input logic vld);
    @(negedge clk);
    req_valid = vld; req_op = op; req_base = base; req_disp = disp; req_st_data = sd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic respond(input logic [31:0] word);
    rsp_valid = 1'b1; rsp_rdata = word;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic chk_flags(input string tag, input logic we, input logic re,
                           input logic el, input logic es);
    chk(tag, {28'd0, mem_we, mem_re, err_load, err_store}, {28'd0, we, re, el, es});
  endtask

  task automatic t_reset;
    chk("R10 addr", mem_addr, 0);
    chk("R10 be/strobes", {mem_be, mem_we, mem_re, ld_valid, err_load, err_store}, 0);
    chk("R10 wdata", mem_wdata, 0);
    chk("R10 ld_data", ld_data, 0);
    chk("R10 fault_addr", fault_addr, 0);
  endtask

  task automatic t_store_byte;
    for (int k = 0; k < 4; k++) begin
      issue(6'd40, 32'h0000_1000, 16'(k), 32'h1234_56A5, 1'b1);
      chk("R1 byte store addr", mem_addr, 32'h1000 + k);
      chk("R2 byte store be", {28'd0, mem_be}, 32'(4'b0001 << k));
      chk("R2 byte store wdata", mem_wdata, 32'hA5A5_A5A5);
      chk_flags("R2 byte store strobes", 1, 0, 0, 0);
    end
  endtask

  task automatic t_store_half;
    issue(6'd41, 32'h0000_2000, 16'd0, 32'h1234_BEEF, 1'b1);
    chk("R3 half lo be", {28'd0, mem_be}, 32'h3);
    chk("R3 half lo wdata", mem_wdata, 32'hBEEF_BEEF);
    issue(6'd41, 32'h0000_2000, 16'd2, 32'h1234_BEEF, 1'b1);
    chk("R3 half hi be", {28'd0, mem_be}, 32'hC);
    chk("R3 half hi wdata", mem_wdata, 32'hBEEF_BEEF);
    chk_flags("R3 half strobes", 1, 0, 0, 0);
  endtask

  task automatic t_store_word;
    issue(6'd43, 32'h0000_2000, 16'hFFFC, 32'hCAFE_0123, 1'b1);
    chk("R1 negative disp addr", mem_addr, 32'h0000_1FFC);
    chk("R4 word be", {28'd0, mem_be}, 32'hF);
    chk("R4 word wdata", mem_wdata, 32'hCAFE_0123);
    issue(6'd43, 32'hFFFF_FFF0, 16'h0020, 32'h0, 1'b1);
    chk("R1 wrap addr", mem_addr, 32'h0000_0010);
  endtask

  task automatic t_misaligned;
    issue(6'd41, 32'h0000_3000, 16'd1, 32'hFFFF_FFFF, 1'b1);
    chk_flags("R5 half store offset 1", 0, 0, 0, 1);
    chk("R5 half store be", {28'd0, mem_be}, 0);
    chk("R5 half store fault_addr", fault_addr, 32'h3001);
    issue(6'd35, 32'h0000_3000, 16'd2, 32'h0, 1'b1);
    chk_flags("R5 word load offset 2", 0, 0, 1, 0);
    chk("R5 word load fault_addr", fault_addr, 32'h3002);
    issue(6'd43, 32'h0000_3000, 16'd3, 32'h0, 1'b1);
    chk_flags("R5 word store offset 3", 0, 0, 0, 1);
    chk("R5 word store be", {28'd0, mem_be}, 0);
    chk("R5 word store fault_addr", fault_addr, 32'h3003);
    issue(6'd32, 32'h0000_3000, 16'd3, 32'h0, 1'b1);
    chk_flags("R5 byte load offset 3 legal", 0, 1, 0, 0);
    chk("R5 fault_addr held", fault_addr, 32'h3003);
    issue(6'd33, 32'h0000_3000, 16'd2, 32'h0, 1'b1);
    chk_flags("R5 half load offset 2 legal", 0, 1, 0, 0);
    chk("R5 fault_addr still held", fault_addr, 32'h3003);
  endtask

  task automatic do_load(input string tag, input logic [5:0] op, input logic [15:0] disp,
                         input logic [31:0] word, input logic [3:0] be_exp,
                         input logic [31:0] exp);
    issue(op, 32'h0000_4000, disp, 32'h0, 1'b1);
    chk({tag, " enables"}, {27'd0, mem_be, mem_re}, {27'd0, be_exp, 1'b1});
    respond(word);
    chk({tag, " valid"}, {31'd0, ld_valid}, 1);
    chk(tag, ld_data, exp);
  endtask

  task automatic t_load_byte;
    do_load("R6 signed byte lane1",   6'd32, 16'd1, 32'h807F_C311, 4'b0010, 32'hFFFF_FFC3);
    do_load("R6 unsigned byte lane1", 6'd36, 16'd1, 32'h807F_C311, 4'b0010, 32'h0000_00C3);
    do_load("R6 signed byte lane2",   6'd32, 16'd2, 32'h807F_C311, 4'b0100, 32'h0000_007F);
    do_load("R6 signed byte lane3",   6'd32, 16'd3, 32'h807F_C311, 4'b1000, 32'hFFFF_FF80);
    do_load("R6 unsigned byte lane0", 6'd36, 16'd0, 32'h807F_C311, 4'b0001, 32'h0000_0011);
  endtask

  task automatic t_load_half;
    do_load("R7 signed half lo",   6'd33, 16'd0, 32'h807F_C311, 4'b0011, 32'hFFFF_C311);
    do_load("R7 unsigned half lo", 6'd37, 16'd0, 32'h807F_C311, 4'b0011, 32'h0000_C311);
    do_load("R7 signed half hi",   6'd33, 16'd2, 32'h807F_C311, 4'b1100, 32'hFFFF_807F);
    do_load("R7 unsigned half hi", 6'd37, 16'd2, 32'h807F_C311, 4'b1100, 32'h0000_807F);
    do_load("R7 positive half hi", 6'd33, 16'd2, 32'h1234_5678, 4'b1100, 32'h0000_1234);
  endtask

  task automatic t_load_word;
    do_load("R8 word load", 6'd35, 16'd4, 32'h8765_4321, 4'b1111, 32'h8765_4321);
  endtask

  task automatic t_idle;
    issue(6'd34, 32'h0000_5000, 16'd0, 32'hFFFF_FFFF, 1'b1);
    chk_flags("R9 unknown opcode strobes", 0, 0, 0, 0);
    chk("R9 unknown opcode be", {28'd0, mem_be}, 0);
    issue(6'd43, 32'h0000_5000, 16'd1, 32'hFFFF_FFFF, 1'b0);
    chk_flags("R9 no request strobes", 0, 0, 0, 0);
    chk("R9 no request be", {28'd0, mem_be}, 0);
    chk("R9 fault_addr untouched", fault_addr, 32'h3003);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_store_byte();
    t_store_half();
    t_store_word();
    t_misaligned();
    t_load_byte();
    t_load_half();
    t_load_word();
    t_idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule